// File: doc/BRIEF.md
# Basic-Rate Line Activation State Controller

This block holds the layer-1 activation state of several basic-rate S/T line interfaces. Each line runs either as network termination (NT), with states G1..G4, or as terminal equipment (TE), with states F1..F8. The `nt_mode` pin picks the mode for each line. Software writes an 8-bit command word into the line chosen by a separate select register. Software reads the state of the selected line back on `rd_state`. Line coding and analog detection are outside the block. It sees the received signal conditions only as three flags per line: INFO0 seen, framed signal recognised, and framing lost.

The command word can force a state directly. A load bit freezes the automatic machine in the forced state. With the load bit clear, the automatic machine runs. A two-bit command starts activation or deactivation. In NT mode a permission bit gates the step from pending activation to active. The activation command clears itself when its target state is reached. The permission bit clears itself when the gated step has been taken. All state changes happen only on a 192 kHz tick enable.

Top module: `l1act_ctrl`

## Requirements
- R1: After reset, every NT line reads state 1 (G1) and every TE line reads state 2 (F2), and `rd_state` shows the line chosen by the select register (select resets to line 0).
- R2: A write with `sel_we` loads `wdata` as the line select. A write with `cmd_we` loads `wdata` into the command word of the selected line only. The command word is split as follows: bits 3..0 hold the forced state code, bit 4 is the load bit, bits 6..5 are the command and bit 7 is the permission. A state changes only on a cycle with `tick` high.
- R3: On a tick with the load bit set and a legal code, the line takes that code. It stays there on later ticks, whatever the receive flags do, for as long as the load bit stays set.
- R4: The legal codes are 1..4 in NT mode and 1..8 in TE mode. A forced illegal code puts the line in G1 (NT) or F2 (TE).
- R5: The load bit acts only on a tick. A load that is set and then cleared between two ticks leaves the state as the automatic machine would have it.
- R6: With the load bit clear, the forced state code has no effect.
- R7: Command 11 starts activation: NT G1 goes to G2, and TE F3 goes to F4. Command 10 starts deactivation: NT G2/G3 goes to G4, and TE F4..F8 goes to F3. Commands 00 and 01 do nothing.
- R8: The command field clears itself on the tick that brings the line to its target. For activation the target is G3 (NT) or F7 (TE). For deactivation the target is G1 (NT) or F3 (TE).
- R9: In NT mode, G2 goes to G3 only on a tick with the permission bit set and the framed-signal flag high. The permission bit clears itself on that step.
- R10: In TE mode the permission bit has no effect on any transition.
- R11: An NT line in G4 stays there for exactly DEACT_TICKS ticks and then goes to G1.
- R12: TE automatic steps: F1 goes to F2 on INFO0, F2 goes to F3, and F3/F4 go to F6 on a framed signal. F6 goes to F7 unless framing is lost, which sends it to F8. F7 goes to F8 on loss of framing. F8 goes to F7 on a framed signal. From F5..F8, INFO0 goes to F3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 192 kHz step enable, one clock wide |
| nt_mode | input | NUM_LINES | Per line: 1 = NT, 0 = TE |
| sel_we | input | 1 | Load line select from `wdata` |
| cmd_we | input | 1 | Load command word of the selected line |
| wdata | input | 8 | Write data |
| rx_info0 | input | NUM_LINES | INFO0 received, per line |
| rx_sync | input | NUM_LINES | Framed signal recognised, per line |
| rx_lost | input | NUM_LINES | Framing lost, per line |
| rd_state | output | 4 | State code of the selected line |

## Verification
A command or select write takes effect at the next clock edge, but it moves no state by itself. A state changes at the clock edge on which `tick` is high, and `rd_state` follows combinationally in the same cycle. The bench drives every write and every tick as a separate one-cycle pulse on the falling edge. It samples `rd_state` on the falling edge after the pulse ends, so each check lands exactly one edge after its stimulus. The G4 dwell is counted tick by tick: the state is checked after each of the DEACT_TICKS ticks.

// File: rtl/l1act_pkg.sv
package l1act_pkg;
  localparam int ST_W  = 4;
  localparam int CMD_W = 8;

  typedef logic [ST_W-1:0] st_t;

  typedef struct packed {
    logic       permit;   // bit 7
    logic [1:0] act;      // bits 6..5
    logic       load;     // bit 4
    st_t        code;     // bits 3..0
  } cmd_t;

  localparam logic [1:0] ACT_DEACT = 2'b10;
  localparam logic [1:0] ACT_START = 2'b11;

  function automatic logic code_ok(input logic nt, input st_t c);
    return nt ? (c >= 4'd1 && c <= 4'd4) : (c >= 4'd1 && c <= 4'd8);
  endfunction

  function automatic st_t rest_code(input logic nt);
    return nt ? 4'd1 : 4'd2;
  endfunction

  function automatic st_t target_code(input logic nt, input logic [1:0] act);
    if (act == ACT_START) return nt ? 4'd3 : 4'd7;
    return nt ? 4'd1 : 4'd3;
  endfunction
endpackage

// File: rtl/l1act_cmd_reg.sv
module l1act_cmd_reg
  import l1act_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cmd_t wdata,
  input  logic clr_act,
  input  logic clr_permit,
  output cmd_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr) begin
      q <= wdata;
    end else begin
      if (clr_act)    q.act    <= 2'b00;
      if (clr_permit) q.permit <= 1'b0;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata)); // R2
endmodule

// File: rtl/l1act_line_fsm.sv
module l1act_line_fsm
  import l1act_pkg::*;
#(
  parameter int DEACT_TICKS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nt_mode,
  input  logic tick,
  input  cmd_t cmd,
  input  logic rx_info0,
  input  logic rx_sync,
  input  logic rx_lost,
  output st_t  state,
  output logic clr_act,
  output logic clr_permit
);
  localparam int CNT_W = $clog2(DEACT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEACT_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  st_t  auto_nxt, nxt;
  logic act_req, deact_req, timer_done, auto_step;

  assign act_req    = cmd.act == ACT_START;
  assign deact_req  = cmd.act == ACT_DEACT;
  assign timer_done = (state == 4'd4) && (cnt == CNT_LAST);
  assign auto_step  = tick && !cmd.load;

  always_comb begin
    auto_nxt = state;
    if (nt_mode) begin
      case (state)
        4'd1: if (act_req || rx_sync) auto_nxt = 4'd2;
        4'd2: if (deact_req) auto_nxt = 4'd4;
              else if (rx_sync && cmd.permit) auto_nxt = 4'd3;
        4'd3: if (deact_req) auto_nxt = 4'd4;
              else if (rx_lost) auto_nxt = 4'd2;
        4'd4: if (timer_done) auto_nxt = 4'd1;
        default: auto_nxt = 4'd1;
      endcase
    end else begin
      case (state)
        4'd1: if (rx_info0) auto_nxt = 4'd2;
        4'd2: auto_nxt = 4'd3;
        4'd3: if (act_req) auto_nxt = 4'd4;
              else if (rx_sync) auto_nxt = 4'd6;
        4'd4: if (deact_req) auto_nxt = 4'd3;
              else if (rx_sync) auto_nxt = 4'd6;
        4'd5: if (deact_req || rx_info0) auto_nxt = 4'd3;
              else if (rx_sync) auto_nxt = 4'd6;
        4'd6: if (deact_req || rx_info0) auto_nxt = 4'd3;
              else if (rx_lost) auto_nxt = 4'd8;
              else auto_nxt = 4'd7;
        4'd7: if (deact_req || rx_info0) auto_nxt = 4'd3;
              else if (rx_lost) auto_nxt = 4'd8;
        4'd8: if (deact_req || rx_info0) auto_nxt = 4'd3;
              else if (rx_sync) auto_nxt = 4'd7;
        default: auto_nxt = 4'd2;
      endcase
    end
  end

  always_comb begin
    if (cmd.load) nxt = code_ok(nt_mode, cmd.code) ? cmd.code : rest_code(nt_mode);
    else          nxt = auto_nxt;
  end

  assign clr_act    = auto_step && cmd.act[1] && (auto_nxt == target_code(nt_mode, cmd.act));
  assign clr_permit = auto_step && nt_mode && (state == 4'd2) && (auto_nxt == 4'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= rest_code(nt_mode);
      cnt   <= '0;
    end else if (tick) begin
      state <= nxt;
      cnt   <= (auto_step && state == 4'd4 && auto_nxt == 4'd4) ? cnt + 1'b1 : '0;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(nt_mode, state)); // R4
  AST_NO_STEP_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cmd.load && code_ok(nt_mode, cmd.code) |=> state == $past(cmd.code)); // R3
  AST_G3_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    nt_mode && tick && !cmd.load && state == 4'd2 && !cmd.permit |=> state != 4'd3); // R9
  AST_G4_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    nt_mode && state == 4'd1 && $past(state) == 4'd4 && !$past(cmd.load) |-> $past(timer_done)); // R11
endmodule

// File: rtl/l1act_ctrl.sv
module l1act_ctrl
  import l1act_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int DEACT_TICKS = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NUM_LINES-1:0] nt_mode,
  input  logic                 sel_we,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     wdata,
  input  logic [NUM_LINES-1:0] rx_info0,
  input  logic [NUM_LINES-1:0] rx_sync,
  input  logic [NUM_LINES-1:0] rx_lost,
  output logic [ST_W-1:0]      rd_state
);
  localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [SEL_W-1:0] sel_q;
  st_t  line_state [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= wdata[SEL_W-1:0];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    cmd_t cmd_q;
    logic wr_line, clr_act, clr_permit;

    assign wr_line = cmd_we && (sel_q == SEL_W'(g));

    l1act_cmd_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr(wr_line), .wdata(cmd_t'(wdata)),
      .clr_act(clr_act), .clr_permit(clr_permit), .q(cmd_q)
    );

    l1act_line_fsm #(.DEACT_TICKS(DEACT_TICKS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .nt_mode(nt_mode[g]), .tick(tick), .cmd(cmd_q),
      .rx_info0(rx_info0[g]), .rx_sync(rx_sync[g]), .rx_lost(rx_lost[g]),
      .state(line_state[g]), .clr_act(clr_act), .clr_permit(clr_permit)
    );
  end

  always_comb begin
    rd_state = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (sel_q == SEL_W'(i)) rd_state = line_state[i];
  end
endmodule

// File: tb/l1act_ctrl_bench.sv
module l1act_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;
  localparam int DT = 4;

  logic clk = 0, rst_n = 0, tick = 0, sel_we = 0, cmd_we = 0;
  logic [N-1:0] nt_mode = 2'b01;
  logic [7:0] wdata = '0;
  logic [N-1:0] rx_info0 = '0, rx_sync = '0, rx_lost = '0;
  logic [3:0] rd_state;
  int n_cmp = 0, n_bad = 0, cur = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l1act_ctrl #(.NUM_LINES(N), .DEACT_TICKS(DT)) u_l1act_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .nt_mode(nt_mode), .sel_we(sel_we),
    .cmd_we(cmd_we), .wdata(wdata), .rx_info0(rx_info0), .rx_sync(rx_sync),
    .rx_lost(rx_lost), .rd_state(rd_state)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_cmp++;
    if (rd_state !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_state actual %0d expected %0d", req, rd_state, exp);
    end
  endtask

  task automatic wr_sel(input int s);
    @(negedge clk); sel_we = 1; wdata = 8'(s);
    @(negedge clk); sel_we = 0; cur = s;
  endtask

  task automatic wr_cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1; wdata = b;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic step(input bit i0, input bit sy, input bit lo);
    @(negedge clk); tick = 1;
    rx_info0 = N'(i0) << cur; rx_sync = N'(sy) << cur; rx_lost = N'(lo) << cur;
    @(negedge clk); tick = 0; rx_info0 = '0; rx_sync = '0; rx_lost = '0;
  endtask

  function automatic logic [3:0] forced(input bit nt, input int c);
    int top = nt ? 4 : 8;
    if (c >= 1 && c <= top) return 4'(c);
    return nt ? 4'd1 : 4'd2;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 NT line0 reset", 4'd1);
    wr_sel(1); check("R1 TE line1 reset", 4'd2);

    // R3 R4: exhaustive forced loads on both modes
    for (int ln = 0; ln < N; ln++) begin
      wr_sel(ln);
      for (int c = 0; c < 16; c++) begin
        wr_cmd(8'h10 | 8'(c));
        step(0, 0, 0);
        check(code_ok_tag(ln == 0, c), forced(ln == 0, c));
      end
      wr_cmd(8'h12);
      step(0, 0, 0);
      step(1, 1, 1);
      check("R3 load freezes state", 4'd2);
    end

    // R2: line1 writes left line0 alone (line0 last loaded 2)
    wr_sel(0); check("R2 select isolates lines", 4'd2);

    // R5: load set then cleared between ticks
    wr_cmd(8'h11); step(0, 0, 0); wr_cmd(8'h00);
    wr_cmd(8'h13); wr_cmd(8'h00); step(0, 0, 0);
    check("R5 load only on tick", 4'd1);

    // NT sequence on line0
    wr_cmd(8'h03); step(0, 0, 0); check("R6 code ignored w/o load", 4'd1);
    wr_cmd(8'h20); step(0, 0, 0); check("R7 cmd 01 no-op", 4'd1);
    wr_cmd(8'h60); step(0, 0, 0); check("R7 activate G1->G2", 4'd2);
    step(0, 1, 0); check("R9 no permit stays G2", 4'd2);
    wr_cmd(8'hE0); step(0, 1, 0); check("R9 permit G2->G3", 4'd3);
    step(0, 0, 1); check("R9 lost G3->G2", 4'd2);
    step(0, 1, 0); check("R9 permit self-cleared", 4'd2);
    wr_cmd(8'h40); step(0, 0, 0); check("R7 deactivate G2->G4", 4'd4);
    for (int k = 1; k < DT; k++) begin
      step(0, 0, 0); check("R11 G4 dwell", 4'd4);
    end
    step(0, 0, 0); check("R11 G4->G1 after count", 4'd1);
    step(0, 0, 0); check("R8 deact cleared at G1", 4'd1);

    // TE sequence on line1
    wr_sel(1);
    wr_cmd(8'h13); step(0, 0, 0); wr_cmd(8'h00);
    step(0, 0, 0); check("R12 F3 idle", 4'd3);
    wr_cmd(8'h80); step(0, 0, 0); check("R10 permit no effect TE", 4'd3);
    wr_cmd(8'h60); step(0, 0, 0); check("R7 activate F3->F4", 4'd4);
    step(0, 1, 0); check("R12 F4->F6", 4'd6);
    step(0, 0, 0); check("R8 F6->F7 target", 4'd7);
    step(1, 0, 0); check("R12 INFO0 F7->F3", 4'd3);
    step(0, 0, 0); check("R8 act self-cleared", 4'd3);
    step(0, 1, 0); step(0, 0, 0); check("R12 F7 again", 4'd7);
    step(0, 0, 1); check("R12 F7->F8", 4'd8);
    step(0, 1, 0); check("R12 F8->F7", 4'd7);
    wr_cmd(8'h40); step(0, 0, 0); check("R7 deactivate F7->F3", 4'd3);
    step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
    check("R8 deact self-cleared", 4'd7);
    wr_cmd(8'h11); step(0, 0, 0); wr_cmd(8'h00);
    step(1, 0, 0); check("R12 F1->F2", 4'd2);
    step(0, 0, 0); check("R12 F2->F3", 4'd3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic string code_ok_tag(input bit nt, input int c);
    int top = nt ? 4 : 8;
    return (c >= 1 && c <= top) ? "R3 forced load" : "R4 illegal code fallback";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule